// File: doc/BRIEF.md
# Write-Back Buffer with Fetch Forwarding

This block sits under a non-blocking cache. Dirty lines that the cache evicts are pushed into a small queue. The queue later sends them to lower memory as line writes, one at a time. Memory can hold off a write by dropping its ready signal. A queued entry keeps its slot after its write is issued. The slot is freed only when memory returns a write response. When all slots are held, the block refuses new evictions, and the cache must stall.

The miss-handling logic asks the block about each line before it fetches that line from memory. The lookup is combinational. The block compares the requested line address against every held entry, including entries whose write is in flight. On a match it returns the buffered data, and its need-memory output tells the miss logic to skip the memory read. If several entries hold the same address, the most recently enqueued one supplies the data, so the newest dirty copy wins.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset the block holds no entries: `enq_ready` is 1, `mem_req_valid` is 0, and a lookup reports `lk_hit` = 0.
- R2: An eviction is stored when `enq_valid` and `enq_ready` are both 1 at a rising edge. `enq_ready` is 0 while DEPTH entries are held. An eviction offered while `enq_ready` is 0 is dropped: it is never written to memory and never hit by a lookup.
- R3: `mem_req_valid` is 1 whenever a held entry has not yet been issued. `mem_req_addr` and `mem_req_data` present the oldest unissued entry. Writes are issued in enqueue order, one per cycle in which `mem_req_valid` and `mem_req_ready` are both 1.
- R4: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the presented address and data stay unchanged in the next cycle, even when new evictions are accepted.
- R5: A 1 on `mem_rsp_valid` at a rising edge frees the oldest issued entry. If no write is outstanding, `mem_rsp_valid` has no effect.
- R6: A lookup with `lk_valid` = 1 is answered in the same cycle. `lk_hit` = 1 and `lk_data` returns the stored line when any held entry, issued or not, has the same address. An entry retiring in that same cycle still counts.
- R7: When several held entries share the looked-up address, `lk_data` is taken from the most recently enqueued one.
- R8: With no matching entry, `lk_hit` = 0, `lk_data` = 0 and `lk_need_mem` = 1. An eviction being enqueued in the same cycle is not yet visible to the lookup.
- R9: Issuing a write does not free its slot. A full buffer stays full until a write response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Evicted dirty line offered |
| enq_addr | input | ADDR_W | Line address of the eviction |
| enq_data | input | DATA_W | Line data of the eviction |
| enq_ready | output | 1 | A free slot exists |
| mem_req_valid | output | 1 | A line write is offered to memory |
| mem_req_ready | input | 1 | Memory accepts the write (0 = back-pressure) |
| mem_req_addr | output | ADDR_W | Address of the offered write |
| mem_req_data | output | DATA_W | Data of the offered write |
| mem_rsp_valid | input | 1 | Write response for the oldest outstanding write |
| lk_valid | input | 1 | Fetch lookup request |
| lk_addr | input | ADDR_W | Line address to fetch |
| lk_hit | output | 1 | Line is held in the buffer |
| lk_data | output | DATA_W | Forwarded line data (0 on miss) |
| lk_need_mem | output | 1 | Lookup missed; a memory read is needed |

## Verification
Retirement and forwarding can occur in the same cycle. A write response for the oldest entry can arrive in the same cycle as a lookup of that entry's address. The bench raises both together and checks that the lookup still hits with the stored data, and that the same lookup misses one cycle later. Enqueue and lookup are also made to coincide: a lookup for a line that is being enqueued in that same cycle must miss, and the same lookup must hit in the next cycle.

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [DATA_W-1:0] enq_data,
  output logic              enq_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_need_mem
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PW-1:0] rd_p, is_p, wr_p;
  logic [CW-1:0] cnt, ocnt;
  logic enq_fire, iss_fire, ret_fire;
  logic hit_any;
  logic [DATA_W-1:0] hit_data;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign enq_ready     = (cnt != CW'(DEPTH));
  assign enq_fire      = enq_valid & enq_ready;
  assign mem_req_valid = (ocnt != cnt);
  assign iss_fire      = mem_req_valid & mem_req_ready;
  assign ret_fire      = mem_rsp_valid & (ocnt != '0);
  assign mem_req_addr  = addr_q[is_p];
  assign mem_req_data  = data_q[is_p];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      is_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
      ocnt <= '0;
    end else begin
      if (enq_fire) wr_p <= nxt(wr_p);
      if (iss_fire) is_p <= nxt(is_p);
      if (ret_fire) rd_p <= nxt(rd_p);
      cnt  <= cnt + CW'(enq_fire) - CW'(ret_fire);
      ocnt <= ocnt + CW'(iss_fire) - CW'(ret_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (enq_fire) begin
      addr_q[wr_p] <= enq_addr;
      data_q[wr_p] <= enq_data;
    end
  end

  always_comb begin
    hit_any  = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      s = int'(rd_p) + i;
      if (s >= DEPTH) s = s - DEPTH;
      if (i < int'(cnt) && addr_q[PW'(s)] == lk_addr) begin
        hit_any  = 1'b1;
        hit_data = data_q[PW'(s)];
      end
    end
  end

  assign lk_hit      = lk_valid & hit_any;
  assign lk_data     = lk_hit ? hit_data : '0;
  assign lk_need_mem = lk_valid & ~hit_any;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data));

  p_full_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !enq_ready && !mem_rsp_valid |=> !enq_ready);

  p_retire_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !enq_ready && mem_rsp_valid && ocnt != '0 |=> enq_ready);

  p_empty_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 |-> !lk_hit && !mem_req_valid);

  p_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ocnt <= cnt);
endmodule

// File: tb/wbuf_fwd_tb.sv
module wbuf_fwd_tb;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEP = 4;

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0, lk_valid = 0;
  logic [AW-1:0] enq_addr = '0, lk_addr = '0, mem_req_addr;
  logic [DW-1:0] enq_data = '0, mem_req_data, lk_data;
  logic enq_ready, mem_req_valid, lk_hit, lk_need_mem;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  wbuf_fwd #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) u_dut (
    .clk, .rst_n, .enq_valid, .enq_addr, .enq_data, .enq_ready,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_req_data,
    .mem_rsp_valid, .lk_valid, .lk_addr, .lk_hit, .lk_data, .lk_need_mem);

  function automatic logic [DW-1:0] dat(input logic [AW-1:0] a, input int v);
    return {a, 16'(v * 7 + 3)};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
    #1;
  endtask

  task automatic push(input logic [AW-1:0] a, input int v);
    @(negedge clk);
    enq_valid = 1; enq_addr = a; enq_data = dat(a, v);
    @(negedge clk);
    enq_valid = 0;
    #1;
  endtask

  task automatic look(input string req, input logic [AW-1:0] a,
                      input logic h, input logic [DW-1:0] d);
    lk_valid = 1; lk_addr = a; #1;
    chk({req, " hit"}, lk_hit, h);
    chk({req, " data"}, lk_data, h ? d : '0);
    chk({req, " need_mem"}, lk_need_mem, !h);
    lk_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 enq_ready", enq_ready, 1);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    look("R1", 16'h0000, 0, '0);
  endtask

  task automatic t_fifo;
    mem_req_ready = 0;
    push(16'h0a00, 1);
    chk("R3 valid after enq", mem_req_valid, 1);
    chk("R3 addr oldest", mem_req_addr, 16'h0a00);
    push(16'h0b00, 2);
    push(16'h0c00, 3);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R4 stall addr", mem_req_addr, 16'h0a00);
      chk("R4 stall data", mem_req_data, dat(16'h0a00, 1));
    end
    look("R6 unissued", 16'h0b00, 1, dat(16'h0b00, 2));
    mem_req_ready = 1;
    chk("R3 order 1", mem_req_addr, 16'h0a00);
    cyc(); chk("R3 order 2", mem_req_addr, 16'h0b00);
    cyc(); chk("R3 order 3", mem_req_addr, 16'h0c00);
    cyc(); chk("R3 all issued", mem_req_valid, 0);
    look("R6 issued", 16'h0a00, 1, dat(16'h0a00, 1));
    chk("R9 slots held", enq_ready, 1);
    push(16'h0d00, 4);
    chk("R9 full", enq_ready, 0);
    enq_valid = 1; enq_addr = 16'h0e00; enq_data = dat(16'h0e00, 5);
    cyc();
    enq_valid = 0;
    chk("R9 still full after issue", enq_ready, 0);
    chk("R2 dropped not issued", mem_req_valid, 0);
    look("R2 dropped", 16'h0e00, 0, '0);
    mem_rsp_valid = 1;
    look("R6 retiring", 16'h0a00, 1, dat(16'h0a00, 1));
    cyc();
    mem_rsp_valid = 0; #1;
    look("R5 retired", 16'h0a00, 0, '0);
    chk("R5 slot freed", enq_ready, 1);
    mem_rsp_valid = 1;
    cyc(); cyc(); cyc();
    mem_rsp_valid = 0; #1;
    look("R5 all retired", 16'h0d00, 0, '0);
    chk("R5 empty valid", mem_req_valid, 0);
  endtask

  task automatic t_spurious;
    mem_req_ready = 0;
    mem_rsp_valid = 1;
    cyc(); cyc();
    mem_rsp_valid = 0;
    push(16'h1100, 1);
    push(16'h1200, 2);
    push(16'h1300, 3);
    chk("R5 ignored rsp, room", enq_ready, 1);
    push(16'h1400, 4);
    chk("R2 full at depth", enq_ready, 0);
    look("R6 last entry", 16'h1400, 1, dat(16'h1400, 4));
    mem_req_ready = 1; mem_rsp_valid = 1;
    for (int i = 0; i < 6; i++) cyc();
    mem_req_ready = 0; mem_rsp_valid = 0; #1;
    chk("R5 drained ready", enq_ready, 1);
    chk("R5 drained valid", mem_req_valid, 0);
  endtask

  task automatic t_dup;
    mem_req_ready = 0;
    push(16'h2200, 1);
    push(16'h2200, 2);
    look("R7 youngest", 16'h2200, 1, dat(16'h2200, 2));
    @(negedge clk);
    enq_valid = 1; enq_addr = 16'h2300; enq_data = dat(16'h2300, 9);
    look("R8 same-cycle enq", 16'h2300, 0, '0);
    cyc();
    enq_valid = 0;
    look("R8 visible next", 16'h2300, 1, dat(16'h2300, 9));
    chk("R3 dup order", mem_req_data, dat(16'h2200, 1));
    mem_req_ready = 1;
    cyc();
    chk("R3 dup second", mem_req_data, dat(16'h2200, 2));
    mem_req_ready = 1; mem_rsp_valid = 1;
    for (int i = 0; i < 5; i++) cyc();
    mem_req_ready = 0; mem_rsp_valid = 0; #1;
    look("R8 empty", 16'h2200, 0, '0);
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fifo();
    t_spurious();
    t_dup();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule